// File: doc/BRIEF.md
# Coupled Four-Phase Handshake Buffer Controller

This block is a one-place buffer controller that couples two four-phase handshakes. On the left side the producer raises `lreq_i`. The block answers on `lack_o`. On the right side the block raises `rreq_o` and the consumer answers on `rack_i`. Each side runs the usual request-up, acknowledge-up, request-down, acknowledge-down cycle.

Two cross dependencies tie the sides together. A left request must arrive before the right request can go up. The right acknowledge must rise before the left acknowledge may drop. Three internal phase bits make every reachable state uniquely encoded. Each next-state bit is one sum-of-products term over the current state and the two sampled inputs.

The controller is clocked. Both inputs pass through a configurable synchronizer chain, and all state, including both handshake outputs, is registered. The block also watches its two inputs for handshake violations. It latches a sticky error flag for each side.

Top module: `hsb_coupler`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `lack_o`, `rreq_o`, `err_left_o` and `err_right_o` are all 0. The three phase bits reset to 1.
- R2: With `lreq_i` and `rack_i` held at 0 after reset, no output ever changes.
- R3: Every edge on `lreq_i` is answered by exactly one `lack_o` edge of the same direction. `lack_o` rises only while `lreq_i` is 1 and falls only while `lreq_i` is 0.
- R4: `rreq_o` rises once per left request, and only after `lreq_i` has risen since the previous `rreq_o` rise.
- R5: `lack_o` falls only after `rack_i` has risen in the current right-side cycle.
- R6: `rreq_o` falls only after `rack_i` has risen, and rises only while `rack_i` is 0.
- R7: No output edge is lost, duplicated or spurious. This holds whether `lreq_i` falls before or after `rack_i` rises. Each edge appears within 64 cycles of the input change that last enables it.
- R8: The left side may raise `lack_o` for a new request while `rack_i` is still high from the previous right cycle. In that case `rreq_o` stays 0 until `rack_i` falls.
- R9: `err_left_o` goes to 1 when the sampled `lreq_i` changes to the value `lack_o` already holds, that is, a rise while `lack_o` is 1 or a fall while `lack_o` is 0. It then stays 1 until `rst`.
- R10: `err_right_o` goes to 1 when the sampled `rack_i` changes to a value different from `rreq_o`, that is, a rise while `rreq_o` is 0 or a fall while `rreq_o` is 1. It then stays 1 until `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_i | input | 1 | Left-side request from the producer |
| rack_i | input | 1 | Right-side acknowledge from the consumer |
| lack_o | output | 1 | Left-side acknowledge, registered |
| rreq_o | output | 1 | Right-side request, registered |
| err_left_o | output | 1 | Sticky flag: left handshake violation seen |
| err_right_o | output | 1 | Sticky flag: right handshake violation seen |

## Verification
The bench builds the block with `SYNC_STAGES` set to 2. Each input therefore takes three cycles to reach the outputs. That delay lets the bench set up every ordering of a left-request fall against a right-acknowledge rise, using delays of a few cycles on either side. It also lets a left request restart while the right acknowledge is still high.

The same latency opens a window in which the bench can withdraw `rack_i` after one cycle, while `rreq_o` is still high. This exercises the right-side error path alongside the left-side one.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  // Controller state: both handshake outputs plus three phase bits
  typedef struct packed {
    logic       lack;
    logic       rreq;
    logic [2:0] ph;
  } hsb_state_t;

  localparam hsb_state_t HSB_RESET = '{lack: 1'b0, rreq: 1'b0, ph: 3'b111};
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk) begin
        if (rst) begin
          ff <= '0;
        end else begin
          ff[0] <= d;
          for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
        end
      end
      assign q = ff[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hsb_core.sv
module hsb_core
  import hsb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lreq,
  input  logic rack,
  output logic lack,
  output logic rreq
);
  hsb_state_t st, nx;

  // Every state bit is recomputed each cycle from the current state
  always_comb begin
    nx.lack  = (st.lack & (st.ph[2] | st.ph[0])) | ~st.ph[1];
    nx.rreq  = st.ph[2] & ((st.ph[0] & (st.lack | lreq)) | st.rreq);
    nx.ph[0] = (st.ph[0] & (~st.ph[1] | ~st.lack)) | (~st.rreq & st.ph[2]);
    nx.ph[1] = ~lreq & (st.ph[0] | st.ph[1]);
    nx.ph[2] = ~rack & ((~st.ph[0] & (~st.ph[1] | ~st.lack)) | st.ph[2]);
  end

  always_ff @(posedge clk) begin
    if (rst) st <= HSB_RESET;
    else     st <= nx;
  end

  assign lack = st.lack;
  assign rreq = st.rreq;
endmodule

// File: rtl/hsb_proto.sv
module hsb_proto (
  input  logic clk,
  input  logic rst,
  input  logic lreq,
  input  logic rack,
  input  logic lack,
  input  logic rreq,
  output logic err_l,
  output logic err_r
);
  logic lreq_q, rack_q;
  logic bad_l, bad_r;

  // Left request may only move to the opposite of the acknowledge;
  // right acknowledge may only move to follow the request.
  assign bad_l = (lreq != lreq_q) && (lreq == lack);
  assign bad_r = (rack != rack_q) && (rack != rreq);

  always_ff @(posedge clk) begin
    if (rst) begin
      lreq_q <= 1'b0;
      rack_q <= 1'b0;
      err_l  <= 1'b0;
      err_r  <= 1'b0;
    end else begin
      lreq_q <= lreq;
      rack_q <= rack;
      err_l  <= err_l | bad_l;
      err_r  <= err_r | bad_r;
    end
  end
endmodule

// File: rtl/hsb_coupler.sv
module hsb_coupler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lreq_i,
  input  logic rack_i,
  output logic lack_o,
  output logic rreq_o,
  output logic err_left_o,
  output logic err_right_o
);
  logic lreq_s, rack_s;

  hsb_sync #(.STAGES(SYNC_STAGES)) u_sync_l (
    .clk(clk), .rst(rst), .d(lreq_i), .q(lreq_s)
  );
  hsb_sync #(.STAGES(SYNC_STAGES)) u_sync_r (
    .clk(clk), .rst(rst), .d(rack_i), .q(rack_s)
  );

  hsb_core u_core (
    .clk(clk), .rst(rst), .lreq(lreq_s), .rack(rack_s),
    .lack(lack_o), .rreq(rreq_o)
  );

  hsb_proto u_proto (
    .clk(clk), .rst(rst), .lreq(lreq_s), .rack(rack_s),
    .lack(lack_o), .rreq(rreq_o), .err_l(err_left_o), .err_r(err_right_o)
  );
endmodule

// File: rtl/hsb_coupler_chk.sv
module hsb_coupler_chk (
  input logic clk,
  input logic rst,
  input logic lreq_s,
  input logic rack_s,
  input logic lack,
  input logic rreq,
  input logic err_l,
  input logic err_r
);
  logic rack_rose_seen, rack_s_q, lack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rack_rose_seen <= 1'b0;
      rack_s_q       <= 1'b0;
      lack_q         <= 1'b0;
    end else begin
      rack_s_q <= rack_s;
      lack_q   <= lack;
      if (lack_q && !lack)         rack_rose_seen <= 1'b0;
      else if (rack_s && !rack_s_q) rack_rose_seen <= 1'b1;
    end
  end

  AST_LACK_RISE_NEEDS_LREQ: assert property (@(posedge clk) disable iff (rst || err_l || err_r)
    $rose(lack) |-> $past(lreq_s)); // R3
  AST_LACK_FALL_NEEDS_LREQ_LOW: assert property (@(posedge clk) disable iff (rst || err_l || err_r)
    $fell(lack) |-> !$past(lreq_s)); // R3
  AST_RREQ_RISE_NEEDS_LEFT: assert property (@(posedge clk) disable iff (rst || err_l || err_r)
    $rose(rreq) |-> ($past(lreq_s) || $past(lack))); // R4
  AST_LACK_FALL_AFTER_RACK: assert property (@(posedge clk) disable iff (rst || err_l || err_r)
    $fell(lack) |-> rack_rose_seen); // R5
  AST_RREQ_FALL_NEEDS_RACK: assert property (@(posedge clk) disable iff (rst || err_l || err_r)
    $fell(rreq) |-> $past(rack_s)); // R6
  AST_RREQ_RISE_NEEDS_RACK_LOW: assert property (@(posedge clk) disable iff (rst || err_l || err_r)
    $rose(rreq) |-> !$past(rack_s)); // R6
endmodule

bind hsb_coupler hsb_coupler_chk u_chk (
  .clk(clk), .rst(rst), .lreq_s(lreq_s), .rack_s(rack_s),
  .lack(lack_o), .rreq(rreq_o), .err_l(err_left_o), .err_r(err_right_o)
);

// File: tb/tb_hsb_coupler.sv
module tb_hsb_coupler;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;

  logic clk = 1'b0, rst = 1'b1, lreq_i = 1'b0, rack_i = 1'b0;
  logic lack_o, rreq_o, err_left_o, err_right_o;

  int checks = 0, errors = 0, overlap = 0;
  bit exp_a[$];
  bit exp_r[$];
  bit mon_en = 1'b0, rpend = 1'b0, ackr_flag = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsb_coupler #(.SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .lreq_i(lreq_i), .rack_i(rack_i),
    .lack_o(lack_o), .rreq_o(rreq_o),
    .err_left_o(err_left_o), .err_right_o(err_right_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic do_reset();
    rst = 1'b1; lreq_i = 1'b0; rack_i = 1'b0;
    mon_en = 1'b0; exp_a.delete(); exp_r.delete();
    rpend = 1'b0; ackr_flag = 1'b0;
    repeat (4) @(negedge clk);
    check(lack_o == 0 && rreq_o == 0, "R1", "outputs in reset", {lack_o, rreq_o}, 0);
    check(err_left_o == 0 && err_right_o == 0, "R1", "errors in reset",
          {err_left_o, err_right_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(lack_o == 0 && rreq_o == 0, "R1", "outputs after release", {lack_o, rreq_o}, 0);
  endtask

  task automatic wait_lack(input bit v);
    int n = 0;
    while (lack_o !== v && n < TMO) begin @(negedge clk); n++; end
    check(lack_o === v, "R7", "lack_o edge within window", lack_o, v);
  endtask

  task automatic wait_rreq(input bit v, input int lim);
    int n = 0;
    while (rreq_o !== v && n < lim) begin @(negedge clk); n++; end
    check(rreq_o === v, "R7", "rreq_o edge within window", rreq_o, v);
  endtask

  // Driver for the producer side; pushes the edges it expects
  task automatic left_env(input int n, input int hold, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lreq_i = 1'b1; rpend = 1'b1;
      exp_a.push_back(1'b1); exp_r.push_back(1'b1);
      wait_lack(1'b1);
      repeat (hold) @(negedge clk);
      lreq_i = 1'b0;
      exp_a.push_back(1'b0);
      wait_lack(1'b0);
      repeat (gap) @(negedge clk);
    end
  endtask

  // Driver for the consumer side
  task automatic right_env(input int n, input int hold, input int gap);
    for (int i = 0; i < n; i++) begin
      wait_rreq(1'b1, 4 * TMO);
      repeat (hold) @(negedge clk);
      rack_i = 1'b1; ackr_flag = 1'b1;
      exp_r.push_back(1'b0);
      wait_rreq(1'b0, TMO);
      repeat (gap) @(negedge clk);
      rack_i = 1'b0;
    end
  endtask

  task automatic scenario(input int n, input int lh, input int lg, input int rh, input int rg);
    fork
      left_env(n, lh, lg);
      right_env(n, rh, rg);
    join
    repeat (12) @(negedge clk);
  endtask

  // Monitor: pops expected edges and checks ordering as outputs move
  initial begin
    bit pa = 1'b0, pr = 1'b0, e;
    forever begin
      @(posedge clk); #1;
      if (mon_en) begin
        if (lack_o !== pa) begin
          if (exp_a.size() == 0) check(0, "R7", "spurious lack_o edge", lack_o, pa);
          else begin e = exp_a.pop_front(); check(lack_o == e, "R3", "lack_o edge", lack_o, e); end
          if (lack_o) begin
            check(lreq_i == 1, "R3", "lreq_i at lack_o rise", lreq_i, 1);
            if (rack_i && !rreq_o) overlap++;
          end else begin
            check(lreq_i == 0, "R3", "lreq_i at lack_o fall", lreq_i, 0);
            check(ackr_flag, "R5", "rack_i rose before lack_o fall", ackr_flag, 1);
            ackr_flag = 1'b0;
          end
        end
        if (rreq_o !== pr) begin
          if (exp_r.size() == 0) check(0, "R7", "spurious rreq_o edge", rreq_o, pr);
          else begin e = exp_r.pop_front(); check(rreq_o == e, "R6", "rreq_o edge", rreq_o, e); end
          if (rreq_o) begin
            check(rpend, "R4", "left request before rreq_o rise", rpend, 1);
            check(rack_i == 0, "R6", "rack_i low at rreq_o rise", rack_i, 0);
            check(!rack_i, "R8", "rreq_o waits for rack_i low", rack_i, 0);
            rpend = 1'b0;
          end else begin
            check(rack_i == 1, "R6", "rack_i high at rreq_o fall", rack_i, 1);
          end
        end
      end
      pa = lack_o; pr = rreq_o;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    mon_en = 1'b1;
    // R2: idle inputs leave everything quiet
    repeat (20) @(negedge clk);
    check(lack_o == 0 && rreq_o == 0, "R2", "idle outputs", {lack_o, rreq_o}, 0);

    scenario(4, 0, 0, 0, 0);   // both sides quick
    scenario(3, 0, 2, 10, 0);  // lreq_i falls before rack_i rises
    scenario(3, 10, 1, 0, 3);  // rack_i rises before lreq_i falls
    scenario(3, 0, 0, 0, 14);  // left restarts while rack_i still high (R8)

    check(exp_a.size() == 0, "R7", "all lack_o edges seen", exp_a.size(), 0);
    check(exp_r.size() == 0, "R7", "all rreq_o edges seen", exp_r.size(), 0);
    check(overlap > 0, "R8", "lack_o rose while rack_i high", overlap, 1);
    check(err_left_o == 0, "R9", "no left error on legal traffic", err_left_o, 0);
    check(err_right_o == 0, "R10", "no right error on legal traffic", err_right_o, 0);

    // R9: re-raise lreq_i while lack_o is still high
    do_reset();
    @(negedge clk); lreq_i = 1'b1;
    wait_lack(1'b1);
    lreq_i = 1'b0;
    repeat (6) @(negedge clk);
    check(lack_o == 1, "R5", "lack_o held without rack_i", lack_o, 1);
    lreq_i = 1'b1;
    repeat (8) @(negedge clk);
    check(err_left_o == 1, "R9", "left violation flagged", err_left_o, 1);
    check(err_right_o == 0, "R10", "right flag untouched", err_right_o, 0);
    repeat (10) @(negedge clk);
    check(err_left_o == 1, "R9", "left flag sticky", err_left_o, 1);

    // R10: drop rack_i while rreq_o is still high
    do_reset();
    @(negedge clk); lreq_i = 1'b1;
    wait_rreq(1'b1, TMO);
    rack_i = 1'b1;
    @(negedge clk); rack_i = 1'b0;
    repeat (8) @(negedge clk);
    check(err_right_o == 1, "R10", "right violation flagged", err_right_o, 1);
    check(err_left_o == 0, "R9", "left flag untouched", err_left_o, 0);
    repeat (10) @(negedge clk);
    check(err_right_o == 1, "R10", "right flag sticky", err_right_o, 1);

    do_reset();
    check(err_right_o == 0 && err_left_o == 0, "R1", "reset clears flags",
          {err_left_o, err_right_o}, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule